// File: doc/BRIEF.md
# Low-Power Clock Enable Controller

This block turns the low-power request bits of a small microcontroller's status word into three clock-enable strobes on the main clock: a run enable for the instruction pipeline, an enable for the auxiliary clock, and an enable for the sub-main clock. Each request bit silences one of these outputs. An interrupt in service lifts all three requests for as long as it lasts. When the service flag drops, the requests that are still set take hold again.

The auxiliary enable follows a low-frequency oscillator tick. The tick arrives asynchronously and is brought into the main-clock domain by a two-flop synchroniser and a rising-edge detector. The sub-main enable comes from a free-running divider on the main clock. Each of the two has a 2-bit ratio select covering 1, 2, 4 and 8. A configuration bit decides whether a pending DMA request may override the sub-main stop request. When that bit is clear, DMA requests have no effect on any output.

Top module: `lpm_clock_gate`

## Requirements
- R1: While rst_n is low, cpu_run_en is 1 and aux_clk_en and sub_clk_en are 0.
- R2: When lp_cpu_stop is 1 and irq_active is 0 at a clock edge, cpu_run_en is 0 after that edge. With lp_cpu_stop at 0, cpu_run_en is 1 after the edge.
- R3: When irq_active is 1 at a clock edge, all three stop requests are ignored for that edge: cpu_run_en is 1 and both dividers deliver their pulses.
- R4: When irq_active falls while lp_cpu_stop is still 1, cpu_run_en returns to 0 one edge later.
- R5: When lp_aux_stop is 1 and irq_active is 0, aux_clk_en stays 0 from the next edge on.
- R6: lp_aux_stop has no effect on sub_clk_en. With sub_div_sel = 0, sub_clk_en is 1 in every cycle.
- R7: When lp_sub_stop is 1, irq_active is 0 and no DMA wake-up applies, sub_clk_en is 0 from the next edge on.
- R8: With lp_aux_stop and lp_sub_stop both 1 and no interrupt, neither aux_clk_en nor sub_clk_en pulses.
- R9: When dma_wake_en and dma_req are both 1, the sub-main divider pulses even while lp_sub_stop is 1. The auxiliary and CPU stop requests are not overridden.
- R10: When dma_wake_en is 0, dma_req has no effect on any output.
- R11: sub_div_sel = k (binary, 0 to 3) gives exactly one sub_clk_en pulse per 2^k main-clock cycles. k = 3 therefore gives one pulse every 8 cycles. For k > 0, each pulse lasts a single cycle.
- R12: Each rising edge of lf_tick is one tick event. aux_div_sel = k gives one aux_clk_en pulse per 2^k tick events. Each pulse lasts one cycle and appears after the third main-clock edge that follows the tick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_cpu_stop | input | 1 | Status-word request to halt instruction execution |
| lp_aux_stop | input | 1 | Status-word request to halt the auxiliary clock |
| lp_sub_stop | input | 1 | Status-word request to halt the sub-main clock |
| irq_active | input | 1 | High while an interrupt is being serviced |
| dma_req | input | 1 | Pending DMA request |
| dma_wake_en | input | 1 | Allows dma_req to override lp_sub_stop |
| lf_tick | input | 1 | Asynchronous low-frequency oscillator tick |
| aux_div_sel | input | 2 | Auxiliary ratio select: 2^k tick events per pulse |
| sub_div_sel | input | 2 | Sub-main ratio select: 2^k main-clock cycles per pulse |
| cpu_run_en | output | 1 | Registered instruction-execution enable |
| aux_clk_en | output | 1 | Registered auxiliary clock-enable pulse |
| sub_clk_en | output | 1 | Registered sub-main clock-enable pulse |

## Verification
The three outputs have different latencies:
- cpu_run_en and the stop decision for both dividers are due one edge after the inputs change.
- An aux_clk_en pulse is due three edges after lf_tick rises.

The bench drives inputs on the falling edge and samples outputs on the falling edge, so each level check lands one full cycle after the change.

Pulse checks first wait a few cycles of settling, longer than the three-edge tick path. They then count pulses over a window that is a whole multiple of every ratio and of the tick period, so the count does not depend on the phase of the free-running dividers.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // ratio select width; a select of k divides by 2**k
  localparam int DIV_SEL_W = 2;
  // counter must hold the largest mask (2**(2**DIV_SEL_W-1) - 1)
  localparam int DIV_CNT_W = (1 << DIV_SEL_W) - 1;

  typedef logic [DIV_SEL_W-1:0] div_sel_t;
  typedef logic [DIV_CNT_W-1:0] div_cnt_t;

  // resolved stop decisions, one per clock domain
  typedef struct packed {
    logic cpu_off;
    logic aux_off;
    logic sub_off;
  } lpm_hold_t;

  // low k bits set for a ratio of 2**k
  function automatic div_cnt_t div_mask(input div_sel_t sel);
    div_cnt_t m;
    m = '0;
    for (int i = 0; i < DIV_CNT_W; i++) begin
      if (i < int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // a divider fires when every masked counter bit is one
  function automatic logic div_hit(input div_cnt_t cnt, input div_sel_t sel);
    return (cnt & div_mask(sel)) == div_mask(sel);
  endfunction

endpackage

// File: rtl/lpm_tick_sync.sv
module lpm_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_evt
);

  // chain[0..STAGES-1] synchronise, chain[STAGES] remembers the prior level
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= tick_async;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign tick_evt = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/lpm_gate_ctrl.sv
module lpm_gate_ctrl (
  input  logic              cpu_stop_req,
  input  logic              aux_stop_req,
  input  logic              sub_stop_req,
  input  logic              irq_active,
  input  logic              dma_req,
  input  logic              dma_wake_en,
  output lpm_pkg::lpm_hold_t hold,
  output logic              wake_irq,
  output logic              wake_dma
);

  assign wake_irq = irq_active;
  assign wake_dma = dma_wake_en & dma_req;

  always_comb begin
    hold.cpu_off = cpu_stop_req & ~wake_irq;
    hold.aux_off = aux_stop_req & ~wake_irq;
    hold.sub_off = sub_stop_req & ~wake_irq & ~wake_dma;
  end

endmodule

// File: rtl/lpm_divider.sv
module lpm_divider
  import lpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  div_sel_t sel,
  input  logic     hold_off,
  output logic     hit,
  output logic     pulse_q
);

  div_cnt_t cnt;

  // counter never stops, so gating does not shift the division phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt + div_cnt_t'(1);
  end

  assign hit = step & div_hit(cnt, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= hit & ~hold_off;
  end

endmodule

// File: rtl/lpm_clock_gate.sv
module lpm_clock_gate
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lp_cpu_stop,
  input  logic                 lp_aux_stop,
  input  logic                 lp_sub_stop,
  input  logic                 irq_active,
  input  logic                 dma_req,
  input  logic                 dma_wake_en,
  input  logic                 lf_tick,
  input  logic [DIV_SEL_W-1:0] aux_div_sel,
  input  logic [DIV_SEL_W-1:0] sub_div_sel,
  output logic                 cpu_run_en,
  output logic                 aux_clk_en,
  output logic                 sub_clk_en
);

  lpm_hold_t hold;
  logic      wake_irq;
  logic      wake_dma;
  logic      tick_evt;
  logic      aux_hit;
  logic      sub_hit;

  lpm_gate_ctrl u_ctrl (
    .cpu_stop_req (lp_cpu_stop),
    .aux_stop_req (lp_aux_stop),
    .sub_stop_req (lp_sub_stop),
    .irq_active   (irq_active),
    .dma_req      (dma_req),
    .dma_wake_en  (dma_wake_en),
    .hold         (hold),
    .wake_irq     (wake_irq),
    .wake_dma     (wake_dma)
  );

  lpm_tick_sync #(.STAGES(SYNC_STAGES)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_async (lf_tick),
    .tick_evt   (tick_evt)
  );

  lpm_divider u_aux_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (tick_evt),
    .sel      (aux_div_sel),
    .hold_off (hold.aux_off),
    .hit      (aux_hit),
    .pulse_q  (aux_clk_en)
  );

  lpm_divider u_sub_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (1'b1),
    .sel      (sub_div_sel),
    .hold_off (hold.sub_off),
    .hit      (sub_hit),
    .pulse_q  (sub_clk_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_run_en <= 1'b1;
    else        cpu_run_en <= ~hold.cpu_off;
  end

endmodule

// File: rtl/lpm_clock_gate_chk.sv
module lpm_clock_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_cpu_stop,
  input logic       lp_aux_stop,
  input logic       lp_sub_stop,
  input logic       irq_active,
  input logic       wake_dma,
  input logic [1:0] sub_div_sel,
  input logic       tick_evt,
  input logic       aux_hit,
  input logic       sub_hit,
  input logic       cpu_run_en,
  input logic       aux_clk_en,
  input logic       sub_clk_en
);

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (cpu_run_en && !aux_clk_en && !sub_clk_en);
    end
  end

  a_r2_cpu_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_cpu_stop && !irq_active) |=> !cpu_run_en);

  a_r2_cpu_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_cpu_stop |=> cpu_run_en);

  a_r3_irq_runs_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    irq_active |=> cpu_run_en);

  a_r3_irq_runs_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && sub_hit) |=> sub_clk_en);

  a_r5_aux_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_aux_stop && !irq_active) |=> !aux_clk_en);

  a_r7_sub_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_sub_stop && !irq_active && !wake_dma) |=> !sub_clk_en);

  a_r9_dma_wakes_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_dma && sub_hit) |=> sub_clk_en);

  a_r11_sub_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_clk_en && sub_div_sel != 2'd0 && $stable(sub_div_sel)) |=> !sub_clk_en);

  a_r12_aux_single: assert property (@(posedge clk) disable iff (!rst_n)
    aux_clk_en |=> !aux_clk_en);

  a_r12_aux_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_hit && !lp_aux_stop) |=> aux_clk_en);

  a_r12_hit_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    aux_hit |-> tick_evt);

endmodule

bind lpm_clock_gate lpm_clock_gate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lp_cpu_stop (lp_cpu_stop),
  .lp_aux_stop (lp_aux_stop),
  .lp_sub_stop (lp_sub_stop),
  .irq_active  (irq_active),
  .wake_dma    (wake_dma),
  .sub_div_sel (sub_div_sel),
  .tick_evt    (tick_evt),
  .aux_hit     (aux_hit),
  .sub_hit     (sub_hit),
  .cpu_run_en  (cpu_run_en),
  .aux_clk_en  (aux_clk_en),
  .sub_clk_en  (sub_clk_en)
);

// File: tb/lpm_clock_gate_tb.sv
`timescale 1ns/100ps
module lpm_clock_gate_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lp_cpu_stop, lp_aux_stop, lp_sub_stop;
  logic       irq_active, dma_req, dma_wake_en;
  logic       lf_tick;
  logic [1:0] aux_div_sel, sub_div_sel;
  logic       cpu_run_en, aux_clk_en, sub_clk_en;

  int checks = 0;
  int errors = 0;
  int aux_n, sub_n;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  // tick: 40 ns period = 10 main cycles, edges off the clock grid
  initial begin
    lf_tick = 1'b0;
    #21;
    forever #20 lf_tick = ~lf_tick;
  end

  lpm_clock_gate u_dut (
    .clk(clk), .rst_n(rst_n),
    .lp_cpu_stop(lp_cpu_stop), .lp_aux_stop(lp_aux_stop), .lp_sub_stop(lp_sub_stop),
    .irq_active(irq_active), .dma_req(dma_req), .dma_wake_en(dma_wake_en),
    .lf_tick(lf_tick), .aux_div_sel(aux_div_sel), .sub_div_sel(sub_div_sel),
    .cpu_run_en(cpu_run_en), .aux_clk_en(aux_clk_en), .sub_clk_en(sub_clk_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_window(input int w);
    aux_n = 0;
    sub_n = 0;
    repeat (w) begin
      @(negedge clk);
      aux_n += int'(aux_clk_en);
      sub_n += int'(sub_clk_en);
    end
  endtask

  task automatic t_reset;
    settle(3);
    chk("R1 cpu_run_en in reset", int'(cpu_run_en), 1);
    chk("R1 aux_clk_en in reset", int'(aux_clk_en), 0);
    chk("R1 sub_clk_en in reset", int'(sub_clk_en), 0);
    rst_n = 1'b1;
    settle(6);
    chk("R2 cpu runs with no stop", int'(cpu_run_en), 1);
    count_window(80);
    chk("R11 sub /8 after reset", sub_n, 10);
    chk("R12 aux /1 after reset", aux_n, 8);
  endtask

  task automatic t_sub_ratios;
    for (int k = 0; k < 4; k++) begin
      sub_div_sel = 2'(k);
      settle(2);
      count_window(64);
      chk($sformatf("R11 sub ratio sel %0d", k), sub_n, 64 >> k);
    end
    // R11 single-cycle pulses at ratio 4
    sub_div_sel = 2'd2;
    settle(2);
    begin
      int pairs = 0;
      logic prev = 1'b0;
      repeat (64) begin
        @(negedge clk);
        if (prev && sub_clk_en) pairs++;
        prev = sub_clk_en;
      end
      chk("R11 sub pulse width", pairs, 0);
    end
    sub_div_sel = 2'd3;
  endtask

  task automatic t_aux_ratios;
    for (int k = 0; k < 4; k++) begin
      aux_div_sel = 2'(k);
      settle(4);
      count_window(80);
      chk($sformatf("R12 aux ratio sel %0d", k), aux_n, 8 >> k);
    end
    aux_div_sel = 2'd0;
  endtask

  task automatic t_cpu_stop;
    lp_cpu_stop = 1'b1;
    @(negedge clk);
    chk("R2 cpu halts one cycle later", int'(cpu_run_en), 0);
    begin
      int highs = 0;
      repeat (20) begin
        @(negedge clk);
        highs += int'(cpu_run_en);
      end
      chk("R2 cpu stays halted", highs, 0);
    end
    irq_active = 1'b1;
    @(negedge clk);
    chk("R3 irq restarts cpu", int'(cpu_run_en), 1);
    settle(5);
    chk("R3 cpu running in service", int'(cpu_run_en), 1);
    irq_active = 1'b0;
    @(negedge clk);
    chk("R4 cpu halts after service", int'(cpu_run_en), 0);
    dma_wake_en = 1'b1;
    dma_req = 1'b1;
    settle(2);
    chk("R9 dma does not wake cpu", int'(cpu_run_en), 0);
    dma_wake_en = 1'b0;
    dma_req = 1'b0;
    lp_cpu_stop = 1'b0;
    @(negedge clk);
    chk("R2 cpu resumes on clear", int'(cpu_run_en), 1);
  endtask

  task automatic t_aux_stop;
    sub_div_sel = 2'd0;
    lp_aux_stop = 1'b1;
    settle(2);
    count_window(80);
    chk("R5 aux halted", aux_n, 0);
    chk("R6 sub every cycle with aux stop", sub_n, 80);
    irq_active = 1'b1;
    settle(4);
    count_window(80);
    chk("R3 aux runs in service", aux_n, 8);
    irq_active = 1'b0;
    lp_aux_stop = 1'b0;
    sub_div_sel = 2'd3;
    settle(4);
  endtask

  task automatic t_sub_stop;
    sub_div_sel = 2'd0;
    settle(2);
    lp_sub_stop = 1'b1;
    @(negedge clk);
    chk("R7 sub off one cycle later", int'(sub_clk_en), 0);
    lp_sub_stop = 1'b0;
    @(negedge clk);
    chk("R7 sub back one cycle later", int'(sub_clk_en), 1);
    sub_div_sel = 2'd3;
    lp_sub_stop = 1'b1;
    settle(2);
    count_window(80);
    chk("R7 sub halted", sub_n, 0);
    chk("R7 aux unaffected by sub stop", aux_n, 8);
    irq_active = 1'b1;
    settle(2);
    count_window(80);
    chk("R3 sub runs in service", sub_n, 10);
    irq_active = 1'b0;
    lp_aux_stop = 1'b1;
    settle(4);
    count_window(80);
    chk("R8 both stops: aux", aux_n, 0);
    chk("R8 both stops: sub", sub_n, 0);
    lp_aux_stop = 1'b0;
  endtask

  task automatic t_dma;
    // lp_sub_stop still set here
    dma_wake_en = 1'b1;
    dma_req = 1'b1;
    settle(2);
    count_window(80);
    chk("R9 dma wakes sub", sub_n, 10);
    lp_aux_stop = 1'b1;
    settle(4);
    count_window(80);
    chk("R9 dma does not wake aux", aux_n, 0);
    lp_aux_stop = 1'b0;
    dma_wake_en = 1'b0;
    settle(4);
    count_window(80);
    chk("R10 dma ignored when disabled: sub", sub_n, 0);
    chk("R10 dma ignored when disabled: aux", aux_n, 8);
    chk("R10 dma ignored when disabled: cpu", int'(cpu_run_en), 1);
    dma_req = 1'b0;
    lp_sub_stop = 1'b0;
    settle(2);
  endtask

  initial begin
    rst_n = 1'b0;
    lp_cpu_stop = 1'b0; lp_aux_stop = 1'b0; lp_sub_stop = 1'b0;
    irq_active = 1'b0; dma_req = 1'b0; dma_wake_en = 1'b0;
    aux_div_sel = 2'd0; sub_div_sel = 2'd3;
    t_reset();
    t_sub_ratios();
    t_aux_ratios();
    t_cpu_stop();
    t_aux_stop();
    t_sub_stop();
    t_dma();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule